// File: doc/BRIEF.md
# Tagged Memory Access Engine

This block stands between on-chip clients and a memory controller and gives clients access to memory words together with their security tags. A client gives a data address and a two-bit command, and never a tag address. The engine finds the tag itself in a two-level tag table that is held in the same memory. The first level has one entry per page, and its location comes from a table base input. The second level has one tag per word and exists only for pages whose words carry different tags.

On reads the engine returns the tag first and then the data, as one response on a shared beat channel. A tag wider than one beat takes several consecutive beats. On writes it stores the tag words in the second-level table and the data word at its own address. A tagged write to a page that has no second-level table is refused. The engine answers it with an error beat and pulses an interrupt so that software can refine the page.

The engine serves one request at a time. It finishes every memory access of a request before it accepts the next one, so a tag and its data can never be seen out of step.

Top module: `tag_assoc_engine`

## Requirements
- R1: A read with command 2'b00 (data only) makes exactly one memory access, at the request address. It answers with one beat that has is_tag=0 and last=1 and carries the memory word.
- R2: A read with command 2'b01 (line with tag) sends TAG_BEATS beats with is_tag=1 in consecutive cycles. Tag word 0 goes first. These are followed in the very next cycle by one data beat with last=1.
- R3: A read with command 2'b10 (tag only) sends only the TAG_BEATS tag beats. Last is set on the final tag beat, and the data address is never accessed.
- R4: The first-level entry of a request is read from cfg_tbl_base + (addr >> PAGE_BITS). Its bits [1:0] give the page kind: 00 untagged, 01 uniform, 10 partial; 11 is handled as untagged. An untagged page yields an all-zero tag and no further table access.
- R5: On a uniformly tagged page, tag word 0 is entry >> 2 and the other tag words are zero. No second-level access is made.
- R6: On a partially tagged page, tag word b is at entry[ADDR_W+1:2] + offset*TAG_BEATS + b, where offset = addr[PAGE_BITS-1:0].
- R7: Writes answer with one beat with is_tag=0, err=0, last=1 and data 0. Command 00 stores only the data word. Command 01 stores the tag words at the R6 addresses and the data word. Command 10 stores only the tag words.
- R8: A tagged write (command 01 or 10) to a page that is not partial makes only the first-level read. It writes nothing and answers with one beat with err=1 and last=1, with tag_irq high in that same cycle.
- R9: Command 2'b11 makes no memory access and answers with one error beat (err=1, last=1) without tag_irq.
- R10: req_ready is low from the cycle after acceptance until the response has finished. Only one memory request is outstanding at a time.
- R11: After reset req_ready is high and rsp_valid, mem_req_valid and tag_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_base | input | ADDR_W | Word address of the first-level tag table |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_cmd | input | 2 | 00 data only, 01 data and tag, 10 tag only, 11 invalid |
| req_addr | input | ADDR_W | Data word address |
| req_wdata | input | DATA_W | Write data word |
| req_wtag | input | DATA_W*TAG_BEATS | Write tag, word 0 in the low bits |
| mem_req_valid | output | 1 | One-cycle memory access request |
| mem_req_write | output | 1 | Memory access is a write |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ack |
| rsp_valid | output | 1 | Response beat present |
| rsp_is_tag | output | 1 | Beat carries a tag word |
| rsp_last | output | 1 | Final beat of the response |
| rsp_err | output | 1 | Request refused |
| rsp_data | output | DATA_W | Beat payload |
| tag_irq | output | 1 | Page refinement needed, with the error beat |

## Verification
The assertions assume that memory raises mem_ack one or more cycles after each single-cycle mem_req_valid, and never without an outstanding request. They also assume that the response channel takes a beat in every cycle, because it has no back-pressure. The bench memory model acknowledges every access exactly one cycle later. The driver raises req_valid only while the engine is idle and drops it right after acceptance, so every request is taken alone. The table layouts placed in the model use only the page kinds and pointers that the requirements define.

// File: rtl/tae_pkg.sv
package tae_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_WITH = 2'b01,
        CMD_ONLY = 2'b10,
        CMD_BAD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        PG_UNTAGGED = 2'b00,
        PG_UNIFORM  = 2'b01,
        PG_PARTIAL  = 2'b10,
        PG_RSVD     = 2'b11
    } page_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1,
        ST_L2,
        ST_DATA,
        ST_SEND
    } state_e;
endpackage

// File: rtl/tae_addr_gen.sv
module tae_addr_gen #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 4,
    parameter int TAG_BEATS = 2,
    parameter int BEAT_W    = 2
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [ADDR_W-1:0] l2_base,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr
);
    logic [ADDR_W-1:0] page_idx;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        page_idx = data_addr >> PAGE_BITS;
        word_off = ADDR_W'(data_addr[PAGE_BITS-1:0]);
        l1_addr  = tbl_base + page_idx;
        l2_addr  = l2_base + word_off * ADDR_W'(TAG_BEATS) + ADDR_W'(beat);
    end
endmodule

// File: rtl/tae_rsp_fmt.sv
module tae_rsp_fmt
    import tae_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TAG_BEATS = 2,
    parameter int BEAT_W    = 2,
    parameter int IDX_W     = 1
) (
    input  logic                             active,
    input  logic                             wr,
    input  cmd_e                             cmd,
    input  logic                             err,
    input  logic                             irq,
    input  logic [BEAT_W-1:0]                beat,
    input  logic [TAG_BEATS-1:0][DATA_W-1:0] tag,
    input  logic [DATA_W-1:0]                data,
    output logic                             valid,
    output logic                             is_tag,
    output logic                             last,
    output logic                             err_o,
    output logic                             irq_o,
    output logic [DATA_W-1:0]                data_o
);
    always_comb begin
        valid  = 1'b0;
        is_tag = 1'b0;
        last   = 1'b0;
        err_o  = 1'b0;
        irq_o  = 1'b0;
        data_o = '0;
        if (active) begin
            valid = 1'b1;
            if (err || wr) begin
                last  = 1'b1;
                err_o = err;
                irq_o = irq;
            end else if (cmd == CMD_NONE) begin
                last   = 1'b1;
                data_o = data;
            end else if (beat < BEAT_W'(TAG_BEATS)) begin
                is_tag = 1'b1;
                data_o = tag[beat[IDX_W-1:0]];
                last   = (cmd == CMD_ONLY) && (beat == BEAT_W'(TAG_BEATS - 1));
            end else begin
                last   = 1'b1;
                data_o = data;
            end
        end
    end
endmodule

// File: rtl/tag_assoc_engine.sv
module tag_assoc_engine
    import tae_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 4,
    parameter int TAG_BEATS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cfg_tbl_base,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [1:0]                  req_cmd,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic [DATA_W*TAG_BEATS-1:0] req_wtag,
    output logic                        mem_req_valid,
    output logic                        mem_req_write,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [DATA_W-1:0]           mem_req_wdata,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        rsp_valid,
    output logic                        rsp_is_tag,
    output logic                        rsp_last,
    output logic                        rsp_err,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        tag_irq
);
    localparam int BEAT_W = $clog2(TAG_BEATS + 1);
    localparam int IDX_W  = (TAG_BEATS > 1) ? $clog2(TAG_BEATS) : 1;

    typedef struct packed {
        state_e                             st;
        logic                               issued;
        logic                               wr;
        cmd_e                               cmd;
        logic [ADDR_W-1:0]                  addr;
        logic [DATA_W-1:0]                  data;
        logic [TAG_BEATS-1:0][DATA_W-1:0]   tag;
        logic [ADDR_W-1:0]                  l2base;
        logic [BEAT_W-1:0]                  beat;
        logic                               err;
        logic                               irq;
    } regs_t;

    regs_t q, d;
    logic [ADDR_W-1:0] l1_addr, l2_addr;
    page_e             kind;

    tae_addr_gen #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .TAG_BEATS(TAG_BEATS), .BEAT_W(BEAT_W)
    ) u_addr (
        .tbl_base (cfg_tbl_base),
        .data_addr(q.addr),
        .l2_base  (q.l2base),
        .beat     (q.beat),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    tae_rsp_fmt #(
        .DATA_W(DATA_W), .TAG_BEATS(TAG_BEATS),
        .BEAT_W(BEAT_W), .IDX_W(IDX_W)
    ) u_fmt (
        .active(q.st == ST_SEND),
        .wr    (q.wr),
        .cmd   (q.cmd),
        .err   (q.err),
        .irq   (q.irq),
        .beat  (q.beat),
        .tag   (q.tag),
        .data  (q.data),
        .valid (rsp_valid),
        .is_tag(rsp_is_tag),
        .last  (rsp_last),
        .err_o (rsp_err),
        .irq_o (tag_irq),
        .data_o(rsp_data)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign kind      = page_e'(mem_rdata[1:0]);

    always_comb begin
        d             = q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr     = req_write;
                    d.cmd    = cmd_e'(req_cmd);
                    d.addr   = req_addr;
                    d.data   = req_wdata;
                    d.tag    = req_wtag;
                    d.err    = 1'b0;
                    d.irq    = 1'b0;
                    d.beat   = '0;
                    d.issued = 1'b0;
                    if (cmd_e'(req_cmd) == CMD_BAD) begin
                        d.err = 1'b1;
                        d.st  = ST_SEND;
                    end else if (cmd_e'(req_cmd) == CMD_NONE) begin
                        d.st = ST_DATA;
                    end else begin
                        d.st = ST_L1;
                    end
                end
            end
            ST_L1: begin
                mem_req_valid = !q.issued;
                mem_req_addr  = l1_addr;
                d.issued      = 1'b1;
                if (mem_ack) begin
                    d.issued = 1'b0;
                    d.l2base = mem_rdata[ADDR_W+1:2];
                    d.beat   = '0;
                    if (kind == PG_PARTIAL) begin
                        d.st = ST_L2;
                    end else if (q.wr) begin
                        d.err = 1'b1;
                        d.irq = 1'b1;
                        d.st  = ST_SEND;
                    end else begin
                        d.tag = '0;
                        if (kind == PG_UNIFORM) d.tag[0] = mem_rdata >> 2;
                        d.st  = (q.cmd == CMD_WITH) ? ST_DATA : ST_SEND;
                    end
                end
            end
            ST_L2: begin
                mem_req_valid = !q.issued;
                mem_req_write = q.wr;
                mem_req_addr  = l2_addr;
                mem_req_wdata = q.tag[q.beat[IDX_W-1:0]];
                d.issued      = 1'b1;
                if (mem_ack) begin
                    d.issued = 1'b0;
                    if (!q.wr) d.tag[q.beat[IDX_W-1:0]] = mem_rdata;
                    if (q.beat == BEAT_W'(TAG_BEATS - 1)) begin
                        d.beat = '0;
                        d.st   = (q.cmd == CMD_WITH) ? ST_DATA : ST_SEND;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                mem_req_valid = !q.issued;
                mem_req_write = q.wr;
                mem_req_addr  = q.addr;
                mem_req_wdata = q.data;
                d.issued      = 1'b1;
                if (mem_ack) begin
                    d.issued = 1'b0;
                    if (!q.wr) d.data = mem_rdata;
                    d.beat = '0;
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (rsp_last) begin
                    d.st   = ST_IDLE;
                    d.beat = '0;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.cmd    <= CMD_NONE;
        end else begin
            q <= d;
        end
    end

    // R2: a tag beat that is not last is followed by another beat at once
    p_tag_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_is_tag && !rsp_last) |=> rsp_valid);

    // R8: the refinement interrupt only comes with the final error beat
    p_irq_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_irq |-> (rsp_valid && rsp_err && rsp_last));

    // R9: an invalid command goes straight to an error beat, no memory access
    p_bad_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cmd == 2'b11)
        |=> (rsp_valid && rsp_err && !tag_irq && !mem_req_valid));

    // R10: the engine is busy after acceptance
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: a memory request is a single-cycle pulse
    p_single_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R11: while idle nothing goes to memory or to the client
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));
endmodule

// File: tb/sim_tag_assoc_engine.sv
module sim_tag_assoc_engine;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TB = 2;
    localparam int BASE = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_cmd = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW*TB-1:0] req_wtag = '0;
    logic req_ready, mem_req_valid, mem_req_write, mem_ack;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, mem_rdata;
    logic rsp_valid, rsp_is_tag, rsp_last, rsp_err, tag_irq;
    logic [DW-1:0] rsp_data;

    always #4 clk = ~clk;

    tag_assoc_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(4), .TAG_BEATS(TB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tbl_base(AW'(BASE)),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wtag(req_wtag), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_is_tag(rsp_is_tag), .rsp_last(rsp_last),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .tag_irq(tag_irq)
    );

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int done_cnt = 0;
    logic [DW-1:0] mem [0:1023];

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) begin
                if (i < 512)       mem[i] <= 32'hD000_0000 + i;
                else if (i < 768)  mem[i] <= 32'h0;
                else               mem[i] <= 32'hA000_0000 + (i - 768);
            end
            mem[BASE+1] <= (32'h155 << 2) | 32'h1;
            mem[BASE+2] <= (32'd768 << 2) | 32'h2;
            mem[BASE+3] <= 32'h3;
        end else if (mem_req_valid) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_req_addr[9:0]];
            if (mem_req_write) mem[mem_req_addr[9:0]] <= mem_req_wdata;
            acc_cnt   <= acc_cnt + 1;
        end
    end

    typedef struct {
        bit        is_tag;
        bit        last;
        bit        err;
        bit        irq;
        logic [31:0] data;
        string     rq;
    } beat_t;
    beat_t exp_q[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic push(input bit t, input bit l, input bit e, input bit i,
                        input logic [31:0] v, input string rq);
        beat_t b;
        b.is_tag = t; b.last = l; b.err = e; b.irq = i; b.data = v; b.rq = rq;
        exp_q.push_back(b);
    endtask

    // monitor: pop and compare every response beat
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected beat", rsp_data, 0);
            end else begin
                beat_t b;
                b = exp_q.pop_front();
                check({rsp_is_tag, rsp_last, rsp_err, tag_irq} == {b.is_tag, b.last, b.err, b.irq},
                      b.rq, "beat flags", {rsp_is_tag, rsp_last, rsp_err, tag_irq},
                      {b.is_tag, b.last, b.err, b.irq});
                check(rsp_data == b.data, b.rq, "beat data", rsp_data, b.data);
            end
            if (rsp_last) done_cnt++;
        end
    end

    task automatic run(input bit wr, input logic [1:0] cmd, input int addr,
                       input logic [31:0] wd, input logic [63:0] wt,
                       input int exp_acc, input string rq);
        int start, target;
        @(negedge clk);
        start = acc_cnt;
        target = done_cnt + 1;
        req_valid = 1'b1; req_write = wr; req_cmd = cmd;
        req_addr = AW'(addr); req_wdata = wd; req_wtag = wt;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
        while (done_cnt < target) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, rq, "missing beats", exp_q.size(), 0);
        check(acc_cnt - start == exp_acc, rq, "memory accesses", acc_cnt - start, exp_acc);
        check(req_ready == 1'b1, "R10", "ready after response", req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready && !rsp_valid && !mem_req_valid && !tag_irq, "R11", "reset outputs",
              {req_ready, rsp_valid, mem_req_valid, tag_irq}, 4'b1000);

        // R1 data-only read
        push(0, 1, 0, 0, 32'hD000_0005, "R1");
        run(0, 2'b00, 5, 0, 0, 1, "R1");

        // R2/R4 untagged page, line with tag
        push(1, 0, 0, 0, 32'h0, "R4");
        push(1, 0, 0, 0, 32'h0, "R4");
        push(0, 1, 0, 0, 32'hD000_0003, "R2");
        run(0, 2'b01, 3, 0, 0, 2, "R4");

        // R5 uniform page
        push(1, 0, 0, 0, 32'h155, "R5");
        push(1, 0, 0, 0, 32'h0, "R5");
        push(0, 1, 0, 0, 32'hD000_0012, "R5");
        run(0, 2'b01, 32'h12, 0, 0, 2, "R5");

        // R6/R2 partial page, offset 5
        push(1, 0, 0, 0, 32'hA000_000A, "R6");
        push(1, 0, 0, 0, 32'hA000_000B, "R6");
        push(0, 1, 0, 0, 32'hD000_0025, "R2");
        run(0, 2'b01, 32'h25, 0, 0, 4, "R6");

        // R3 tag only, partial offset 7
        push(1, 0, 0, 0, 32'hA000_000E, "R3");
        push(1, 1, 0, 0, 32'hA000_000F, "R3");
        run(0, 2'b10, 32'h27, 0, 0, 3, "R3");

        // R4 reserved kind treated as untagged
        push(1, 0, 0, 0, 32'h0, "R4");
        push(1, 1, 0, 0, 32'h0, "R4");
        run(0, 2'b10, 32'h30, 0, 0, 1, "R4");

        // R7 data-only write
        push(0, 1, 0, 0, 32'h0, "R7");
        run(1, 2'b00, 6, 32'h1111_2222, 0, 1, "R7");
        check(mem[6] == 32'h1111_2222, "R7", "data word", mem[6], 32'h1111_2222);

        // R7 line-with-tag write to partial page, offset 1
        push(0, 1, 0, 0, 32'h0, "R7");
        run(1, 2'b01, 32'h21, 32'h3333_4444, 64'h0000_BBBB_0000_AAAA, 4, "R7");
        check(mem[770] == 32'hAAAA && mem[771] == 32'hBBBB, "R7", "tag words",
              {mem[771], mem[770]}, 64'h0000_BBBB_0000_AAAA);
        check(mem[32'h21] == 32'h3333_4444, "R7", "tagged data", mem[32'h21], 32'h3333_4444);

        // R7 tag-only write, offset 2, data untouched
        push(0, 1, 0, 0, 32'h0, "R7");
        run(1, 2'b10, 32'h22, 32'h5555_6666, 64'h0000_0002_0000_0001, 3, "R7");
        check(mem[772] == 32'h1 && mem[773] == 32'h2, "R7", "tag-only words",
              {mem[773], mem[772]}, 64'h0000_0002_0000_0001);
        check(mem[32'h22] == 32'hD000_0022, "R7", "data kept", mem[32'h22], 32'hD000_0022);

        // R6 read back the written tag
        push(1, 0, 0, 0, 32'hAAAA, "R6");
        push(1, 0, 0, 0, 32'hBBBB, "R6");
        push(0, 1, 0, 0, 32'h3333_4444, "R6");
        run(0, 2'b01, 32'h21, 0, 0, 4, "R6");

        // R8 tagged write to uniform and untagged pages
        push(0, 1, 1, 1, 32'h0, "R8");
        run(1, 2'b01, 32'h13, 32'h7777_7777, 64'h9, 1, "R8");
        check(mem[32'h13] == 32'hD000_0013, "R8", "data not written", mem[32'h13], 32'hD000_0013);
        push(0, 1, 1, 1, 32'h0, "R8");
        run(1, 2'b10, 4, 0, 64'h9, 1, "R8");

        // R9 invalid command
        push(0, 1, 1, 0, 32'h0, "R9");
        run(0, 2'b11, 7, 0, 0, 0, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule